// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block drives the board pins that bring up a crystal oscillator and the PLL it feeds. It keeps shadow copies of a two-bit GPIO output register and a two-bit output-enable register. Bit 0 of each is the crystal power-up pin, which is active high. Bit 1 is the PLL power-down pin, which is also active high, so the PLL runs while that pin is low. A single request says whether to power on or power off, and which of the two pins it covers. The sequencer then steps through the register writes in a fixed order and counts the settling time between steps in clock cycles.

Every register write appears on a one-cycle write strobe with a target code. If the register path answers a write with an error in that same cycle, the sequence stops and reports failure. A power-on request does nothing to the pins when the crystal sense input already reads high, because another agent is then using the clock and a new sequence could glitch it. Every power-on request, including one that skips the pin steps, finishes by writing the status register to clear its sticky target-abort bit.

Top module: `xtal_pll_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until the end of the sequence, and requests made while it is high have no effect.
- R2: Each output-enable write (`cfg_sel_o` = 2) sets `oe_o` to its old value OR the selected bits (bit 0 crystal, bit 1 PLL). No `oe_o` bit ever returns to 0 after reset, and a power-on request with no crystal step makes no output-enable write.
- R3: On a power-on request that selects the crystal while `xtal_sense_i` is low, the first write is an output write (`cfg_sel_o` = 1). It drives `xtal_pu_o` high and, if the PLL is also selected, drives `pll_pd_o` high in the same write. An output-enable write follows, and then XTAL_US microseconds of wait.
- R4: On a power-on request that selects the PLL while `xtal_sense_i` is low, the sequence clears `pll_pd_o` with an output write and then waits PLL_US microseconds. This happens after the crystal steps, if those are present.
- R5: If `xtal_sense_i` is high when a power-on request is taken, the sequence makes no output or output-enable write.
- R6: Every power-on request ends with one status write (`cfg_sel_o` = 3). A power-off request makes no status write.
- R7: A power-off request makes a single output write, in which `xtal_pu_o` is cleared if the crystal is selected and `pll_pd_o` is set if the PLL is selected. An output-enable write follows, and there is no wait.
- R8: When `cfg_err_i` is high during a write cycle, that write does not change the pins or `oe_o`. The sequence then ends at once, and `done_o` and `fail_o` are high together.
- R9: `done_o` is a one-cycle pulse. With N1 = CLK_KHZ*XTAL_US/1000 and N2 = CLK_KHZ*PLL_US/1000, it appears this many clock edges after the accepting edge: 4+N1+N2 for a full power-on, 3+N1 for crystal only, 2+N2 for PLL only, 1 when the request is skipped or selects nothing, and 2 for power-off.
- R10: `xtal_pu_o` and `pll_pd_o` change only on the clock edge that ends an output write without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| req_xtal_i | input | 1 | Request covers the crystal pin |
| req_pll_i | input | 1 | Request covers the PLL pin |
| xtal_sense_i | input | 1 | Readback of the crystal power-up pin |
| cfg_err_i | input | 1 | Error response to the write in the current cycle |
| cfg_wr_o | output | 1 | Register write strobe |
| cfg_sel_o | output | 2 | Write target: 1 output, 2 output enable, 3 status clear |
| xtal_pu_o | output | 1 | Crystal power-up pin (output shadow bit 0) |
| pll_pd_o | output | 1 | PLL power-down pin (output shadow bit 1) |
| oe_o | output | 2 | Output-enable shadow |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| fail_o | output | 1 | Sequence aborted by a write error; valid with done_o |

## Verification
The assertions check four things on every cycle: output-enable bits never clear, pins and enables change only after an error-free write to their own register, writes occur only while busy, and failure never appears without the done pulse. The ordering of steps, the skip decision taken from the crystal sense input, the exact settling lengths and the single status clear per power-on can be shown only through the bench's scenarios. The bench checks these by measuring the latency of each request, counting status writes and comparing the final pin state against a table.

// File: rtl/xtal_pll_seq_pkg.sv
package xtal_pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_XOUT,
    ST_XOE,
    ST_XWAIT,
    ST_POUT,
    ST_PWAIT,
    ST_STAT,
    ST_OFFOUT,
    ST_OFFOE
  } seq_state_e;

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_OUT  = 2'd1;
  localparam logic [1:0] SEL_OE   = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int XTAL_BIT = 0;
  localparam int PLLPD_BIT = 1;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/gpio_shadow.sv
module gpio_shadow #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_we_i,
  input  logic [W-1:0] out_d_i,
  input  logic         oe_we_i,
  input  logic [W-1:0] oe_d_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] oe_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q_o <= '0;
    else if (out_we_i) out_q_o <= out_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q_o <= '0;
    else if (oe_we_i) oe_q_o <= oe_d_i;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import xtal_pll_seq_pkg::*;
#(
  parameter int TW = 8,
  parameter int XTAL_CYC = 10,
  parameter int PLL_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_on_i,
  input  logic          req_xtal_i,
  input  logic          req_pll_i,
  input  logic          xtal_sense_i,
  input  logic          cfg_err_i,
  input  logic [1:0]    out_q_i,
  input  logic [1:0]    oe_q_i,
  input  logic          tmr_expired_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          out_we_o,
  output logic [1:0]    out_d_o,
  output logic          oe_we_o,
  output logic [1:0]    oe_d_o,
  output logic          cfg_wr_o,
  output logic [1:0]    cfg_sel_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam logic [TW-1:0] XTAL_LOAD = TW'(XTAL_CYC - 1);
  localparam logic [TW-1:0] PLL_LOAD  = TW'(PLL_CYC - 1);

  seq_state_e state_q, state_d;
  logic selx_q, selp_q;
  logic cap_en;
  logic done_d, fail_d;

  always_comb begin
    state_d    = state_q;
    cap_en     = (state_q == ST_IDLE) && req_i;
    cfg_wr_o   = 1'b0;
    cfg_sel_o  = SEL_NONE;
    out_we_o   = 1'b0;
    out_d_o    = out_q_i;
    oe_we_o    = 1'b0;
    oe_d_o     = oe_q_i | {selp_q, selx_q};
    tmr_load_o = 1'b0;
    tmr_val_o  = XTAL_LOAD;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!req_on_i)         state_d = ST_OFFOUT;
          else if (xtal_sense_i) state_d = ST_STAT;    // clock already in use
          else if (req_xtal_i)   state_d = ST_XOUT;
          else if (req_pll_i)    state_d = ST_POUT;
          else                   state_d = ST_STAT;
        end
      end
      ST_XOUT: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_OUT;
        out_d_o[XTAL_BIT]  = 1'b1;
        out_d_o[PLLPD_BIT] = out_q_i[PLLPD_BIT] | selp_q;
        if (cfg_err_i) begin
          state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else begin
          out_we_o = 1'b1; state_d = ST_XOE;
        end
      end
      ST_XOE: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_OE;
        if (cfg_err_i) begin
          state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else begin
          oe_we_o = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o = XTAL_LOAD;
          state_d = ST_XWAIT;
        end
      end
      ST_XWAIT: begin
        if (tmr_expired_i) state_d = selp_q ? ST_POUT : ST_STAT;
      end
      ST_POUT: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_OUT;
        out_d_o[PLLPD_BIT] = 1'b0;
        if (cfg_err_i) begin
          state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else begin
          out_we_o = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o = PLL_LOAD;
          state_d = ST_PWAIT;
        end
      end
      ST_PWAIT: begin
        if (tmr_expired_i) state_d = ST_STAT;
      end
      ST_STAT: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_STAT;
        state_d = ST_IDLE;
        done_d = 1'b1;
        fail_d = cfg_err_i;
      end
      ST_OFFOUT: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_OUT;
        out_d_o[XTAL_BIT]  = out_q_i[XTAL_BIT] & ~selx_q;
        out_d_o[PLLPD_BIT] = out_q_i[PLLPD_BIT] | selp_q;
        if (cfg_err_i) begin
          state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else begin
          out_we_o = 1'b1; state_d = ST_OFFOE;
        end
      end
      ST_OFFOE: begin
        cfg_wr_o = 1'b1;
        cfg_sel_o = SEL_OE;
        oe_we_o = !cfg_err_i;
        state_d = ST_IDLE;
        done_d = 1'b1;
        fail_d = cfg_err_i;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selx_q <= 1'b0;
      selp_q <= 1'b0;
    end else if (cap_en) begin
      selx_q <= req_xtal_i;
      selp_q <= req_pll_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= done_d;
      fail_o <= fail_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/xtal_pll_seq.sv
module xtal_pll_seq
  import xtal_pll_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned XTAL_US = 1000,
  parameter int unsigned PLL_US  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       req_on_i,
  input  logic       req_xtal_i,
  input  logic       req_pll_i,
  input  logic       xtal_sense_i,
  input  logic       cfg_err_i,
  output logic       cfg_wr_o,
  output logic [1:0] cfg_sel_o,
  output logic       xtal_pu_o,
  output logic       pll_pd_o,
  output logic [1:0] oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o
);
  localparam int unsigned XTAL_RAW = (CLK_KHZ * XTAL_US) / 1000;
  localparam int unsigned PLL_RAW  = (CLK_KHZ * PLL_US) / 1000;
  localparam int XTAL_CYC = (XTAL_RAW < 1) ? 1 : int'(XTAL_RAW);
  localparam int PLL_CYC  = (PLL_RAW < 1) ? 1 : int'(PLL_RAW);
  localparam int MAX_CYC  = (XTAL_CYC > PLL_CYC) ? XTAL_CYC : PLL_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          out_we, oe_we;
  logic [1:0]    out_d, oe_d, out_q, oe_q;

  seq_fsm #(
    .TW(TW), .XTAL_CYC(XTAL_CYC), .PLL_CYC(PLL_CYC)
  ) i_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .req_i(req_i), .req_on_i(req_on_i), .req_xtal_i(req_xtal_i),
    .req_pll_i(req_pll_i), .xtal_sense_i(xtal_sense_i), .cfg_err_i(cfg_err_i),
    .out_q_i(out_q), .oe_q_i(oe_q), .tmr_expired_i(tmr_expired),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .out_we_o(out_we), .out_d_o(out_d), .oe_we_o(oe_we), .oe_d_o(oe_d),
    .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  settle_timer #(.W(TW)) i_timer (
    .clk(clk), .rst_n(rst_sync_n),
    .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(tmr_expired)
  );

  gpio_shadow #(.W(2)) i_shadow (
    .clk(clk), .rst_n(rst_sync_n),
    .out_we_i(out_we), .out_d_i(out_d),
    .oe_we_i(oe_we), .oe_d_i(oe_d),
    .out_q_o(out_q), .oe_q_o(oe_q)
  );

  assign xtal_pu_o = out_q[XTAL_BIT];
  assign pll_pd_o  = out_q[PLLPD_BIT];
  assign oe_o      = oe_q;
endmodule

// File: rtl/xtal_pll_seq_chk.sv
module xtal_pll_seq_chk
  import xtal_pll_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       cfg_wr_o,
  input logic [1:0] cfg_sel_o,
  input logic       cfg_err_i,
  input logic       xtal_pu_o,
  input logic       pll_pd_o,
  input logic [1:0] oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       fail_o
);
  a_r2_oe_never_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (($past(oe_o) & ~oe_o) == 2'b00));

  a_r2_oe_changes_on_oe_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(oe_o) |-> $past(cfg_wr_o && (cfg_sel_o == SEL_OE) && !cfg_err_i));

  a_r10_pins_change_on_out_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable({pll_pd_o, xtal_pu_o}) |-> $past(cfg_wr_o && (cfg_sel_o == SEL_OUT) && !cfg_err_i));

  a_r1_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_wr_o |-> busy_o);

  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fail_o |-> done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

bind xtal_pll_seq xtal_pll_seq_chk i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o), .cfg_err_i(cfg_err_i),
  .xtal_pu_o(xtal_pu_o), .pll_pd_o(pll_pd_o), .oe_o(oe_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/test_xtal_pll_seq.sv
module test_xtal_pll_seq;
  // CLK_KHZ = 10 gives N1 = 10 and N2 = 50 cycles
  logic clk = 1'b0;
  logic rst_n;
  logic req_i, req_on_i, req_xtal_i, req_pll_i, xtal_sense_i, cfg_err_i;
  logic err_mode;
  logic cfg_wr_o, xtal_pu_o, pll_pd_o, busy_o, done_o, fail_o;
  logic [1:0] cfg_sel_o, oe_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign cfg_err_i = err_mode && cfg_wr_o;

  xtal_pll_seq #(.CLK_KHZ(10), .XTAL_US(1000), .PLL_US(5000)) i_xtal_pll_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_on_i(req_on_i),
    .req_xtal_i(req_xtal_i), .req_pll_i(req_pll_i), .xtal_sense_i(xtal_sense_i),
    .cfg_err_i(cfg_err_i), .cfg_wr_o(cfg_wr_o), .cfg_sel_o(cfg_sel_o),
    .xtal_pu_o(xtal_pu_o), .pll_pd_o(pll_pd_o), .oe_o(oe_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  // {on, xtal, pll, sense, latency[7:0], {pll_pd,xtal_pu}[1:0], oe[1:0], status_writes}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd2,  2'b00, 2'b01, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd52, 2'b00, 2'b01, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd13, 2'b01, 2'b01, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'd1,  2'b01, 2'b01, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd2,  2'b11, 2'b11, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd64, 2'b01, 2'b11, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'd2,  2'b10, 2'b11, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  2'b10, 2'b11, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic on, input logic x, input logic p, input logic sense,
                         output int lat, output int clr, output logic failed);
    bit got;
    @(negedge clk);
    req_on_i = on; req_xtal_i = x; req_pll_i = p; xtal_sense_i = sense; req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_i = 1'b0;
    lat = 0; clr = 0; got = 1'b0; failed = 1'b0;
    while (!got && lat < 1000) begin
      if (cfg_wr_o && cfg_sel_o == 2'd3) clr++;
      if (done_o) begin
        got = 1'b1;
        failed = fail_o;
      end else begin
        @(posedge clk);
        lat++;
        @(negedge clk);
      end
    end
    if (!got) check("R9 watchdog on done", 0, 1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 global watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, clr;
    logic failed;
    string tag;
    rst_n = 1'b0; req_i = 1'b0; req_on_i = 1'b0; req_xtal_i = 1'b0;
    req_pll_i = 1'b0; xtal_sense_i = 1'b0; err_mode = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R1 busy after reset", int'(busy_o), 0);
    check("R9 done after reset", int'(done_o), 0);
    check("R2 oe after reset", int'(oe_o), 0);
    check("R10 pins after reset", int'({pll_pd_o, xtal_pu_o}), 0);

    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      v = VEC[i];
      run_req(v[16], v[15], v[14], v[13], lat, clr, failed);
      tag = !v[16] ? "R7" : (v[13] ? "R5" : (v[15] ? "R3" : "R4"));
      check($sformatf("R9 latency vec%0d", i), lat, int'(v[12:5]));
      check($sformatf("%s pins vec%0d", tag, i), int'({pll_pd_o, xtal_pu_o}), int'(v[4:3]));
      check($sformatf("R2 oe vec%0d", i), int'(oe_o), int'(v[2:1]));
      check($sformatf("R6 status writes vec%0d", i), clr, int'(v[0]));
      check($sformatf("R8 no fail vec%0d", i), int'(failed), 0);
    end

    // write error on first output write: pins stay 10, oe stays 11
    err_mode = 1'b1;
    run_req(1'b1, 1'b1, 1'b0, 1'b0, lat, clr, failed);
    err_mode = 1'b0;
    check("R8 fail flag", int'(failed), 1);
    check("R8 abort latency", lat, 1);
    check("R8 pins unchanged", int'({pll_pd_o, xtal_pu_o}), 2);
    check("R8 oe unchanged", int'(oe_o), 3);
    check("R8 no status write", clr, 0);

    // request held during a busy sequence is ignored
    @(negedge clk);
    req_on_i = 1'b1; req_xtal_i = 1'b1; req_pll_i = 1'b0; xtal_sense_i = 1'b0; req_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_on_i = 1'b0; req_xtal_i = 1'b1; req_pll_i = 1'b1;
    check("R1 busy after accept", int'(busy_o), 1);
    lat = 0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    req_i = 1'b0;
    while (!done_o && lat < 1000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    check("R1 latency with ignored request", lat, 13);
    check("R1 pins after ignored request", int'({pll_pd_o, xtal_pu_o}), 3);
    clr = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (done_o || busy_o) clr++;
    end
    check("R1 no second sequence", clr, 0);
    check("R1 pins still held", int'({pll_pd_o, xtal_pu_o}), 3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule